// File: doc/BRIEF.md
# Data Memory with Hex Display Register

This block is the load/store side of a single-cycle 32-bit core. In each cycle it takes a byte address, write data, a write enable and a 3-bit access-size code. It returns load data as a 32-bit value, sign-extended or zero-extended as the code asks. The low 8 KiB of the address space is RAM. A single 32-bit register at the top word of the address space holds the value shown on an eight-digit hexadecimal display. That register can be written but not read back.

Reads are combinational, so load data is ready in the same cycle as the address. Stores and display updates take effect on the rising clock edge. The address is decoded into one of three regions: RAM, the display word, or unmapped. Stores go through a lane stage that builds the per-byte enables and replicated write data. Loads go through an extraction and extension stage. Memory is little-endian and accesses are naturally aligned. A synchronous reset clears the display register and leaves the RAM contents as they were.

The block has no control state machine. The regions act as its modes: a RAM access, a display-word access and an unmapped access. For a store, the move from one state to the next is the byte-enable merge on the clock edge.

Top module: `dmem_hexdisp`

## Requirements
- R1: Byte addresses 0x00000000 to 0x00001FFF map to 8 KiB of RAM. A word stored at any aligned address in that range, including the first and last words, reads back unchanged.
- R2: Load data is combinational. After the address or size changes, `rd_data` follows with no clock edge in between.
- R3: Memory is little-endian. The byte at address A is bits [8*(A mod 4)+7 : 8*(A mod 4)] of its word.
- R4: Size code 000 (byte) and 001 (halfword) sign-extend the loaded value to 32 bits. Code 010 loads a full word.
- R5: Size code 100 (byte) and 101 (halfword) zero-extend the loaded value to 32 bits.
- R6: A byte store (000) or halfword store (001) changes only the addressed bytes. The other bytes of the word keep their values.
- R7: A halfword access picks its lane with address bit 1 and ignores bit 0. A word access ignores address bits [1:0].
- R8: A store to the word at 0xFFFFFFFC updates the display register on the clock edge. `disp_word` shows that value, and digit n is bits [4n+3:4n]. A load from that word returns zero.
- R9: A load from an unmapped address returns zero. A store to an unmapped address changes neither the RAM nor the display register.
- R10: A synchronous reset clears the display register to zero and leaves the RAM contents unchanged.
- R11: A byte or halfword store to the display word changes only the addressed bytes of the display register.
- R12: Size codes 011, 110 and 111 are not valid. A load with one of them returns zero, and a store with one of them writes nothing.
- R13: No store takes place while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the display register |
| addr | input | 32 | Byte address |
| wr_data | input | 32 | Store data, with the value in the low bits |
| wr_en | input | 1 | Store enable |
| size | input | 3 | Access-size and sign code |
| rd_data | output | 32 | Extended load data |
| disp_word | output | 32 | Display register, eight 4-bit digits |

## Verification
A single known word is read with every size code at every byte offset. The word has the sign bit set in some bytes and clear in others, so sign extension, zero extension and lane order can each be told apart. Narrow stores are followed by full-word reads, which expose any write to a neighbouring byte. Accesses at 0x2000, at the last RAM word and at the display word separate the three regions and detect aliasing. Reset is applied with the display register and the RAM both holding values, which shows which of the two the reset clears.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    localparam logic [2:0] SZ_BYTE  = 3'b000;
    localparam logic [2:0] SZ_HALF  = 3'b001;
    localparam logic [2:0] SZ_WORD  = 3'b010;
    localparam logic [2:0] SZ_BYTEU = 3'b100;
    localparam logic [2:0] SZ_HALFU = 3'b101;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_DISP = 2'd2
    } region_e;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode #(
    parameter int          RAM_BYTES = 8192,
    parameter logic [31:0] DISP_ADDR = 32'hFFFF_FFFC
) (
    input  logic [31:0]       addr,
    output dmem_pkg::region_e region
);
    localparam int OFF_W = $clog2(RAM_BYTES);

    always_comb begin
        if (addr[31:OFF_W] == '0)
            region = dmem_pkg::RGN_RAM;
        else if (addr[31:2] == DISP_ADDR[31:2])
            region = dmem_pkg::RGN_DISP;
        else
            region = dmem_pkg::RGN_NONE;
    end
endmodule

// File: rtl/dmem_store_lane.sv
module dmem_store_lane
    import dmem_pkg::*;
(
    input  logic [2:0]  size,
    input  logic [1:0]  offs,
    input  logic [31:0] wr_data,
    output logic [3:0]  byte_en,
    output logic [31:0] lane_data
);
    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                byte_en   = 4'b0001 << offs;
                lane_data = {4{wr_data[7:0]}};
            end
            SZ_HALF: begin
                byte_en   = offs[1] ? 4'b1100 : 4'b0011;
                lane_data = {2{wr_data[15:0]}};
            end
            SZ_WORD: begin
                byte_en   = 4'b1111;
                lane_data = wr_data;
            end
            default: begin
                byte_en   = 4'b0000;
                lane_data = '0;
            end
        endcase
    end

    always_comb begin
        if (size == SZ_HALF)
            assert ($countones(byte_en) == 2 && (byte_en[0] ^ byte_en[2])) else $error("AST_HALF_LANES"); // R7
        if (size == SZ_BYTE)
            assert ($onehot0(byte_en) && byte_en != 4'b0) else $error("AST_BYTE_LANE"); // R6
    end
endmodule

// File: rtl/dmem_load_ext.sv
module dmem_load_ext
    import dmem_pkg::*;
(
    input  logic [2:0]  size,
    input  logic [1:0]  offs,
    input  logic [31:0] word,
    output logic [31:0] rd_data
);
    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_comb begin
        sel_b = word[8*offs +: 8];
        sel_h = offs[1] ? word[31:16] : word[15:0];
        unique case (size)
            SZ_BYTE:  rd_data = {{24{sel_b[7]}}, sel_b};
            SZ_HALF:  rd_data = {{16{sel_h[15]}}, sel_h};
            SZ_WORD:  rd_data = word;
            SZ_BYTEU: rd_data = {24'b0, sel_b};
            SZ_HALFU: rd_data = {16'b0, sel_h};
            default:  rd_data = '0;
        endcase
    end

    always_comb begin
        if (size == SZ_BYTEU)
            assert (rd_data[31:8] == 24'b0) else $error("AST_BU_HIGH_ZERO"); // R5
        if (size == SZ_HALFU)
            assert (rd_data[31:16] == 16'b0) else $error("AST_HU_HIGH_ZERO"); // R5
    end
endmodule

// File: rtl/dmem_hexdisp.sv
module dmem_hexdisp
    import dmem_pkg::*;
#(
    parameter int          RAM_BYTES = 8192,
    parameter logic [31:0] DISP_ADDR = 32'hFFFF_FFFC
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] addr,
    input  logic [31:0] wr_data,
    input  logic        wr_en,
    input  logic [2:0]  size,
    output logic [31:0] rd_data,
    output logic [31:0] disp_word
);
    localparam int LANES = 4;
    localparam int WORDS = RAM_BYTES / LANES;
    localparam int IDX_W = $clog2(WORDS);

    region_e     region;
    logic [3:0]  byte_en;
    logic [31:0] lane_data;
    logic [31:0] ram_word;
    logic [31:0] ext_data;
    logic [31:0] disp_q;
    logic [IDX_W-1:0] idx;
    logic        ram_wr;
    logic        disp_wr;

    assign idx     = addr[IDX_W+1:2];
    assign ram_wr  = wr_en && (region == RGN_RAM);
    assign disp_wr = wr_en && (region == RGN_DISP);

    dmem_decode #(.RAM_BYTES(RAM_BYTES), .DISP_ADDR(DISP_ADDR)) u_dec (
        .addr   (addr),
        .region (region)
    );

    dmem_store_lane u_st (
        .size      (size),
        .offs      (addr[1:0]),
        .wr_data   (wr_data),
        .byte_en   (byte_en),
        .lane_data (lane_data)
    );

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [7:0] bank [WORDS];
            always_ff @(posedge clk) begin
                if (ram_wr && byte_en[g])
                    bank[idx] <= lane_data[8*g +: 8];
            end
            assign ram_word[8*g +: 8] = bank[idx];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_q <= '0;
        end else if (disp_wr) begin
            for (int b = 0; b < LANES; b++)
                if (byte_en[b])
                    disp_q[8*b +: 8] <= lane_data[8*b +: 8];
        end
    end

    dmem_load_ext u_ld (
        .size    (size),
        .offs    (addr[1:0]),
        .word    (ram_word),
        .rd_data (ext_data)
    );

    assign rd_data   = (region == RGN_RAM) ? ext_data : '0;
    assign disp_word = disp_q;

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> disp_word == 32'b0); // R10
    AST_DISP_WORD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (disp_wr && size == SZ_WORD) |=> disp_word == $past(wr_data)); // R8
    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !disp_wr |=> $stable(disp_word)); // R9
    AST_DISP_NARROW: assert property (@(posedge clk) disable iff (rst)
        (disp_wr && size == SZ_BYTE && addr[1:0] == 2'd0) |=> disp_word[31:8] == $past(disp_word[31:8])); // R11
    always_comb begin
        if (region != RGN_RAM)
            assert (rd_data == 32'b0) else $error("AST_UNMAPPED_ZERO"); // R9
    end
endmodule

// File: tb/tb_dmem_hexdisp.sv
module tb_dmem_hexdisp;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] addr;
    logic [31:0] wr_data;
    logic        wr_en;
    logic [2:0]  size;
    logic [31:0] rd_data;
    logic [31:0] disp_word;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dmem_hexdisp dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .size(size), .rd_data(rd_data), .disp_word(disp_word)
    );

    // we | size | addr | wdata | expected rd_data | requirement number
    localparam int NV = 28;
    localparam logic [107:0] VEC [NV] = '{
        {1'b1, 3'd2, 32'h0000_0000, 32'h8765_43A1, 32'h0,         8'd1},  // R1 store
        {1'b0, 3'd2, 32'h0000_0000, 32'h0,         32'h8765_43A1, 8'd1},  // R1
        {1'b0, 3'd0, 32'h0000_0000, 32'h0,         32'hFFFF_FFA1, 8'd4},  // R4
        {1'b0, 3'd4, 32'h0000_0000, 32'h0,         32'h0000_00A1, 8'd5},  // R5
        {1'b0, 3'd0, 32'h0000_0001, 32'h0,         32'h0000_0043, 8'd3},  // R3
        {1'b0, 3'd4, 32'h0000_0002, 32'h0,         32'h0000_0065, 8'd3},  // R3
        {1'b0, 3'd4, 32'h0000_0003, 32'h0,         32'h0000_0087, 8'd3},  // R3
        {1'b0, 3'd1, 32'h0000_0002, 32'h0,         32'hFFFF_8765, 8'd4},  // R4
        {1'b0, 3'd1, 32'h0000_0000, 32'h0,         32'h0000_43A1, 8'd4},  // R4
        {1'b0, 3'd5, 32'h0000_0002, 32'h0,         32'h0000_8765, 8'd5},  // R5
        {1'b0, 3'd5, 32'h0000_0003, 32'h0,         32'h0000_8765, 8'd7},  // R7
        {1'b0, 3'd2, 32'h0000_0003, 32'h0,         32'h8765_43A1, 8'd7},  // R7
        {1'b1, 3'd0, 32'h0000_0001, 32'hFFFF_FFCC, 32'h0,         8'd6},  // R6 store
        {1'b0, 3'd2, 32'h0000_0000, 32'h0,         32'h8765_CCA1, 8'd6},  // R6
        {1'b1, 3'd1, 32'h0000_0003, 32'hFFFF_1234, 32'h0,         8'd6},  // R6 store
        {1'b0, 3'd2, 32'h0000_0000, 32'h0,         32'h1234_CCA1, 8'd6},  // R6
        {1'b1, 3'd2, 32'h0000_1FFC, 32'hCAFE_F00D, 32'h0,         8'd1},  // R1 store
        {1'b0, 3'd2, 32'h0000_1FFC, 32'h0,         32'hCAFE_F00D, 8'd1},  // R1
        {1'b0, 3'd4, 32'h0000_1FFF, 32'h0,         32'h0000_00CA, 8'd3},  // R3
        {1'b1, 3'd2, 32'h0000_2000, 32'hDEAD_BEEF, 32'h0,         8'd9},  // R9 store
        {1'b0, 3'd2, 32'h0000_2000, 32'h0,         32'h0,         8'd9},  // R9
        {1'b0, 3'd2, 32'h0000_0000, 32'h0,         32'h1234_CCA1, 8'd9},  // R9
        {1'b0, 3'd2, 32'h0000_0000, 32'h5555_5555, 32'h1234_CCA1, 8'd13}, // R13 no enable
        {1'b0, 3'd2, 32'h0000_0000, 32'h0,         32'h1234_CCA1, 8'd13}, // R13
        {1'b1, 3'd3, 32'h0000_0000, 32'h0,         32'h0,         8'd12}, // R12 store
        {1'b0, 3'd2, 32'h0000_0000, 32'h0,         32'h1234_CCA1, 8'd12}, // R12
        {1'b0, 3'd3, 32'h0000_0000, 32'h0,         32'h0,         8'd12}, // R12
        {1'b0, 3'd7, 32'h0000_1FFC, 32'h0,         32'h0,         8'd12}  // R12
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [2:0] s, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = w; size = s; addr = a; wr_data = d;
        #1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; size = 3'd2; addr = 32'h0; wr_data = 32'h0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R10 reset display", disp_word, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][107], VEC[i][106:104], VEC[i][103:72], VEC[i][71:40]);
            if (!VEC[i][107])
                check($sformatf("R%0d vector %0d", VEC[i][7:0], i), rd_data, VEC[i][39:8]);
        end
        check("R9 unmapped store left display", disp_word, 32'h0);

        // R2: address change without a clock edge
        @(negedge clk);
        wr_en = 1'b0; size = 3'd2; addr = 32'h0;
        #1 check("R2 comb read a", rd_data, 32'h1234_CCA1);
        addr = 32'h0000_1FFC;
        #1 check("R2 comb read b", rd_data, 32'hCAFE_F00D);
        size = 3'd0;
        #1 check("R2 comb size change", rd_data, 32'h0000_000D);

        // R8: display word store and digit layout
        drive(1'b1, 3'd2, 32'hFFFF_FFFC, 32'h89AB_CDEF);
        drive(1'b0, 3'd2, 32'hFFFF_FFFC, 32'h0);
        check("R8 display value", disp_word, 32'h89AB_CDEF);
        check("R8 digit0", {28'b0, disp_word[3:0]}, 32'hF);
        check("R8 digit7", {28'b0, disp_word[31:28]}, 32'h8);
        check("R8 display read zero", rd_data, 32'h0);

        // R11: narrow store into display
        drive(1'b1, 3'd0, 32'hFFFF_FFFE, 32'h0000_005A);
        drive(1'b0, 3'd2, 32'h0000_0000, 32'h0);
        check("R11 display byte store", disp_word, 32'h895A_CDEF);
        drive(1'b1, 3'd1, 32'hFFFF_FFFC, 32'h0000_7788);
        drive(1'b0, 3'd2, 32'h0000_0000, 32'h0);
        check("R11 display half store", disp_word, 32'h895A_7788);

        // R9: unmapped store does not touch display
        drive(1'b1, 3'd2, 32'h8000_0000, 32'h0BAD_0BAD);
        drive(1'b0, 3'd2, 32'h0000_0000, 32'h0);
        check("R9 unmapped store display", disp_word, 32'h895A_7788);

        // R10: reset clears display, keeps RAM
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 reset display", disp_word, 32'h0);
        check("R10 RAM kept", rd_data, 32'h1234_CCA1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule